// File: doc/BRIEF.md
# Configuration memory address sequencer

This block is the control core of a configuration memory that streams a stored bitstream into an FPGA. It keeps the read address and decides, on every clock, whether that address advances, holds or rewinds. The decision depends on the chip-enable, on the output-enable/reset input, on a busy handshake and on a restart pulse. From the same state it flags whether the data and clock-out pins would be driven, whether the downstream device in a chain may be enabled, and whether the part sits in standby or in reduced power. Tri-state pins are represented by enable flags. An internal word array, loaded through a simple write port, supplies the data word at the current address.

The address space can be split into four equal revision banks. When revisioning is strapped on, a 2-bit select chooses the bank. Rewinds then go to the start of that bank, and streaming stops at the bank's last word. When revisioning is off, rewinds go to address 0 and streaming runs to the terminal count (the all-ones address). Stopping at a bank end and stopping at the terminal count differ in one respect: only the terminal count releases the cascade output.

Top module: `cfg_addr_seq`

## Requirements
- R1: While `ce_n` is 1, the address is loaded with the rewind address on each clock, regardless of `oe_rst_n`. In this state `standby`=1, `cascade_n`=1, `data_drive`=0, `clk_drive`=0 and `reduced`=0.
- R2: While `ce_n` is 0 and `oe_rst_n` is 0, the address is loaded with the rewind address on each clock. In this state `data_drive`=0, `clk_drive`=0, `cascade_n`=1, `standby`=0 and `reduced`=0.
- R3: While `ce_n` is 0 and `oe_rst_n` is 1, and the address is below the active end address, the address rises by one on each clock unless a freeze or a restart applies. In this state `data_drive`=1, `clk_drive`=1, `cascade_n`=1 and `reduced`=0.
- R4: When a bank end address below the terminal count is reached, the address holds. In this state `data_drive`=0, `clk_drive`=0, `cascade_n`=1 and `reduced`=1.
- R5: When the address equals the terminal count (all ones), the address holds. In this state `cascade_n`=0, `data_drive`=0, `clk_drive`=0 and `reduced`=1. `cascade_n` is 0 in no other case.
- R6: With `par_mode`=1 and `decomp_en`=0, `busy`=1 during streaming keeps the address unchanged. `data_drive` and `clk_drive` stay 1, and `data_out` keeps its value.
- R7: With `par_mode`=0 or `decomp_en`=1, `busy` has no effect, and the address keeps counting.
- R8: A 0-to-1 change of `restart` between two consecutive clock samples loads the rewind address on that clock. It takes priority over busy, over holding and over counting.
- R9: The rewind address is `rev_sel`*256 when `rev_en`=1 and 0 otherwise. The end address is `rev_sel`*256+255 when `rev_en`=1 and 1023 otherwise. These values apply to the default 10-bit address, where each bank spans a quarter of the space.
- R10: When `rst_n` is 0 at a clock edge, the address becomes 0 and the stored `restart` sample is cleared.
- R11: A clock with `wr_en`=1 stores `wr_data` at `wr_addr`. `data_out` always shows the word stored at the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_rst_n | input | 1 | Output enable when 1, address reset when 0 |
| restart | input | 1 | Configuration restart; rising edge rewinds |
| busy | input | 1 | Freeze request from the receiving device |
| rev_sel | input | 2 | Revision bank select |
| rev_en | input | 1 | Revisioning strap |
| par_mode | input | 1 | Parallel output mode strap |
| decomp_en | input | 1 | Decompression strap |
| wr_en | input | 1 | Word store write enable |
| wr_addr | input | 10 | Word store write address |
| wr_data | input | 8 | Word store write data |
| addr | output | 10 | Current read address |
| data_out | output | 8 | Word at the current address |
| data_drive | output | 1 | Data pins would be driven |
| clk_drive | output | 1 | Clock-out pin would be driven |
| cascade_n | output | 1 | Cascade enable to the next device, active low |
| standby | output | 1 | Standby power state |
| reduced | output | 1 | Reduced power state |

## Verification
The properties assume that `rev_sel` and `rev_en` stay steady while a stream is running, so that each end comparison refers to one fixed bank. The bench changes them only while `ce_n` is 1 or `oe_rst_n` is 0. The assertions also assume that every input is stable across each rising edge. The bench therefore drives all inputs on the falling edge. It writes the word store only while the address is held, and it makes each restart pulse at least one clock long, so that one rising edge is seen per pulse.

// File: rtl/cfg_seq_pkg.sv
// Package: shared types for the configuration address sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package cfg_seq_pkg;
    typedef enum logic [2:0] {
        M_STANDBY,
        M_HELD,
        M_RUN,
        M_BANK_STOP,
        M_TC_STOP
    } seq_mode_t;
endpackage

// File: rtl/rev_bank_map.sv
// Module: rev_bank_map
// Splits the address space into 2**REV_W equal banks and picks the rewind
// and end addresses of the selected bank. With revisioning off it returns
// the whole space. Assumes ADDR_W > REV_W.
module rev_bank_map #(
    parameter int ADDR_W = 10,
    parameter int REV_W  = 2
) (
    input  logic [REV_W-1:0]  rev_sel,
    input  logic              rev_en,
    output logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] end_addr
);
    localparam int NBANK  = 1 << REV_W;
    localparam int SPAN_W = ADDR_W - REV_W;

    logic [ADDR_W-1:0] bank_lo [NBANK];
    logic [ADDR_W-1:0] bank_hi [NBANK];

    // Build the per-bank first and last address table.
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        assign bank_lo[g] = {REV_W'(g), {SPAN_W{1'b0}}};
        assign bank_hi[g] = {REV_W'(g), {SPAN_W{1'b1}}};
    end

    // Choose the bank bounds, or the full space when revisioning is off.
    always_comb begin
        if (rev_en) begin
            start_addr = bank_lo[rev_sel];
            end_addr   = bank_hi[rev_sel];
        end else begin
            start_addr = '0;
            end_addr   = '1;
        end
    end
endmodule

// File: rtl/restart_edge.sv
// Module: restart_edge
// Rising-edge detector for the restart input, using a registered copy.
// Assumes restart is synchronous to clk.
module restart_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic rise
);
    logic prev_q;

    // Remember last cycle's restart sample.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= restart;
    end

    assign rise = restart & ~prev_q;
endmodule

// File: rtl/word_store.sv
// Module: word_store
// Data word array with a single write port and an asynchronous read at
// the current address. Assumes the array is loaded before it is read.
module word_store #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one word per write-enabled clock.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/addr_stepper.sv
// Module: addr_stepper
// Address register: rewinds on clear or restart, holds at or past the end
// address or under freeze, otherwise counts up by one.
// Assumes end_addr never exceeds the all-ones terminal count.
module addr_stepper #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              rise,
    input  logic              freeze,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic at_end;
    assign at_end = (addr >= end_addr);

    // Next address: reset, rewind, hold or step.
    always_ff @(posedge clk) begin
        if (!rst_n)               addr <= '0;
        else if (clear || rise)   addr <= start_addr;
        else if (at_end || freeze) addr <= addr;
        else                      addr <= addr + ONE;
    end

    // R1 R2: a held-off device loads the rewind address.
    p_clear_rewind_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> addr == $past(start_addr));

    // R3: streaming below the end steps by exactly one.
    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !rise && !freeze && !at_end) |=> addr == $past(addr) + ONE);

    // R4: at the end address the counter does not move.
    p_end_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !rise && at_end) |=> $stable(addr));

    // R6: freeze keeps the address.
    p_freeze_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !rise && freeze) |=> $stable(addr));

    // R8: a restart edge always rewinds.
    p_restart_rewind_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> addr == $past(start_addr));
endmodule

// File: rtl/cfg_addr_seq.sv
// Module: cfg_addr_seq (top)
// Configuration memory address sequencer: address control, pin drive
// flags, cascade enable and power status. Assumes rev_sel/rev_en change
// only while the address is held.
module cfg_addr_seq
    import cfg_seq_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int REV_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_rst_n,
    input  logic              restart,
    input  logic              busy,
    input  logic [REV_W-1:0]  rev_sel,
    input  logic              rev_en,
    input  logic              par_mode,
    input  logic              decomp_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data_out,
    output logic              data_drive,
    output logic              clk_drive,
    output logic              cascade_n,
    output logic              standby,
    output logic              reduced
);
    localparam logic [ADDR_W-1:0] TERM = '1;

    logic [ADDR_W-1:0] start_addr;
    logic [ADDR_W-1:0] end_addr;
    logic              rise;
    logic              freeze;
    logic              clear;
    seq_mode_t         mode;

    assign clear  = ce_n | ~oe_rst_n;
    assign freeze = busy & par_mode & ~decomp_en;

    rev_bank_map #(.ADDR_W(ADDR_W), .REV_W(REV_W)) u_map (
        .rev_sel(rev_sel), .rev_en(rev_en),
        .start_addr(start_addr), .end_addr(end_addr)
    );

    restart_edge u_edge (
        .clk(clk), .rst_n(rst_n), .restart(restart), .rise(rise)
    );

    addr_stepper #(.ADDR_W(ADDR_W)) u_step (
        .clk(clk), .rst_n(rst_n), .clear(clear), .rise(rise),
        .freeze(freeze), .start_addr(start_addr), .end_addr(end_addr),
        .addr(addr)
    );

    word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(addr), .rd_data(data_out)
    );

    // Classify the present state from enables and address position.
    always_comb begin
        if (ce_n)                 mode = M_STANDBY;
        else if (!oe_rst_n)       mode = M_HELD;
        else if (addr == TERM)    mode = M_TC_STOP;
        else if (addr >= end_addr) mode = M_BANK_STOP;
        else                      mode = M_RUN;
    end

    // Derive pin drive, cascade and power flags from the state.
    always_comb begin
        data_drive = (mode == M_RUN);
        clk_drive  = (mode == M_RUN);
        cascade_n  = (mode != M_TC_STOP);
        standby    = (mode == M_STANDBY);
        reduced    = (mode == M_TC_STOP) || (mode == M_BANK_STOP);
    end

    // R1: standby never drives pins and keeps the chain disabled.
    p_standby_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> (standby && cascade_n && !data_drive && !clk_drive && !reduced));

    // R5: cascade released only at terminal count of an enabled device.
    p_cascade_tc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cascade_n |-> (addr == TERM && !ce_n && oe_rst_n));

    // R6: a freeze during streaming keeps the data word.
    p_data_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_drive && freeze && !rise && !wr_en) |=> $stable(data_out));
endmodule

// File: tb/cfg_addr_seq_test.sv
`timescale 1ns/1ps
module cfg_addr_seq_test;
    localparam int AW = 10;
    localparam int DW = 8;
    localparam int TC = 1023;

    logic clk = 1'b0;
    logic rst_n, ce_n, oe_rst_n, restart, busy, rev_en, par_mode, decomp_en, wr_en;
    logic [1:0] rev_sel;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [AW-1:0] addr;
    logic [DW-1:0] data_out;
    logic data_drive, clk_drive, cascade_n, standby, reduced;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int m_addr = 0;
    int m_prev = 0;
    int m_mem [1024];

    always #2 clk = ~clk;

    cfg_addr_seq uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_rst_n(oe_rst_n),
        .restart(restart), .busy(busy), .rev_sel(rev_sel), .rev_en(rev_en),
        .par_mode(par_mode), .decomp_en(decomp_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .addr(addr), .data_out(data_out),
        .data_drive(data_drive), .clk_drive(clk_drive), .cascade_n(cascade_n),
        .standby(standby), .reduced(reduced)
    );

    function automatic int m_start();
        return rev_en ? int'(rev_sel) * 256 : 0;
    endfunction
    function automatic int m_end();
        return rev_en ? int'(rev_sel) * 256 + 255 : TC;
    endfunction

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at addr %0d", tag, what, act, exp, m_addr);
        end
    endtask

    // Compare all outputs to the model, then advance the model over one edge.
    task automatic cyc(input string tag);
        int e_dd, e_casc, e_red;
        #1;
        if (rst_n) begin
            e_dd = 0; e_casc = 1; e_red = 0;
            if (!ce_n && oe_rst_n) begin
                if (m_addr == TC) begin e_casc = 0; e_red = 1; end
                else if (m_addr >= m_end()) e_red = 1;
                else e_dd = 1;
            end
            cmp(tag, "addr", int'(addr), m_addr);
            cmp(tag, "data_out", int'(data_out), m_mem[m_addr]);
            cmp(tag, "data_drive", int'(data_drive), e_dd);
            cmp(tag, "clk_drive", int'(clk_drive), e_dd);
            cmp(tag, "cascade_n", int'(cascade_n), e_casc);
            cmp(tag, "standby", int'(standby), int'(ce_n));
            cmp(tag, "reduced", int'(reduced), e_red);
        end
        @(posedge clk);
        if (wr_en) m_mem[wr_addr] = int'(wr_data);
        if (!rst_n) begin
            m_addr = 0; m_prev = 0;
        end else begin
            int rise;
            rise = (restart && m_prev == 0) ? 1 : 0;
            m_prev = int'(restart);
            if (ce_n || !oe_rst_n || rise == 1) m_addr = m_start();
            else if (m_addr >= m_end()) m_addr = m_addr;
            else if (busy && par_mode && !decomp_en) m_addr = m_addr;
            else m_addr = m_addr + 1;
        end
        @(negedge clk);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 0; ce_n = 1; oe_rst_n = 1; restart = 0; busy = 0;
        rev_sel = 0; rev_en = 0; par_mode = 0; decomp_en = 0;
        wr_en = 0; wr_addr = '0; wr_data = '0;
        @(negedge clk);
        run(3, "R10");
        rst_n = 1;
        #1;
        cmp("R10", "addr after reset", int'(addr), 0);
        // R11: load the word store while held in standby.
        for (int i = 0; i < 1024; i++) begin
            wr_en = 1; wr_addr = AW'(i); wr_data = DW'((i * 37 + 5) % 256);
            cyc("R11");
        end
        wr_en = 0;
        run(2, "R1");
        // R1: oe toggling in standby has no effect.
        oe_rst_n = 0; run(2, "R1");
        oe_rst_n = 1; run(2, "R1");
        // R2: enabled but held in reset.
        ce_n = 0; oe_rst_n = 0; run(3, "R2");
        // R3 R5: full stream to terminal count, then hold.
        oe_rst_n = 1; run(1030, "R3");
        cmp("R5", "addr at terminal count", int'(addr), TC);
        run(4, "R5");
        // R11: rewrite a word at the held address.
        wr_en = 1; wr_addr = AW'(TC); wr_data = 8'hA5; cyc("R11");
        wr_en = 0; run(2, "R11");
        // R2: oe low rewinds.
        oe_rst_n = 0; run(2, "R2");
        // R9 R4: revision bank 1 stream stops at its end.
        rev_en = 1; rev_sel = 2'd1; run(2, "R9");
        oe_rst_n = 1; run(270, "R4");
        cmp("R4", "addr at bank end", int'(addr), 511);
        // R9 R5: bank 3 ends at terminal count.
        oe_rst_n = 0; rev_sel = 2'd3; run(2, "R9");
        oe_rst_n = 1; run(262, "R5");
        // R6: busy freeze in parallel mode.
        oe_rst_n = 0; rev_en = 0; run(2, "R2");
        oe_rst_n = 1; run(10, "R3");
        par_mode = 1; busy = 1; run(6, "R6");
        busy = 0; run(4, "R6");
        // R7: busy ignored when serial, and when decompression is on.
        par_mode = 0; busy = 1; run(5, "R7");
        par_mode = 1; decomp_en = 1; run(5, "R7");
        decomp_en = 0; busy = 0; run(3, "R7");
        // R8: restart edge with busy active, then held high (one edge only).
        busy = 1; restart = 1; run(4, "R8");
        busy = 0; run(6, "R8");
        restart = 0; run(2, "R8");
        // R8: restart in a bank rewinds to the bank start.
        oe_rst_n = 0; rev_en = 1; rev_sel = 2'd2; run(2, "R9");
        oe_rst_n = 1; run(20, "R3");
        restart = 1; run(1, "R8");
        restart = 0; run(5, "R8");
        // R1: standby entered mid-stream, then resume.
        ce_n = 1; run(3, "R1");
        ce_n = 0; run(5, "R3");
        // R10: reset mid-stream.
        rst_n = 0; run(1, "R10");
        rst_n = 1;
        #1;
        cmp("R10", "addr after mid reset", int'(addr), 0);
        @(negedge clk);
        m_addr = int'(addr);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule